// File: doc/BRIEF.md
# Accumulator ALU with Multiplier

This block is the arithmetic core of a small 16-bit signal processor. It holds a 32-bit accumulator, two 16-bit multiplier operand registers (X and Y) and a 32-bit product register P. The product register always holds twice the unsigned product of X and Y. When an operation-valid strobe is high, one operation code and one 16-bit operand are applied at the rising clock edge. The operand may come from a register, a memory word or an immediate; the block does not care which.

Two-operand arithmetic and logic work against the accumulator's upper half. Single-operand shifts, negation and absolute value work on all 32 bits. Multiply-accumulate and multiply-load steps combine the accumulator with P and reload the operand registers. The zero and negative flags always describe a full 32-bit value. A combinational condition evaluator turns those flags into a branch-taken signal for the sequencer.

The block has no state machine. Its only sequential state is the set of data registers, and every register changes in the same edge as the operation that updates it.

Top module: `dsp_acc_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the accumulator, X, Y, P, Z and N to zero.
- R2: P equals (X * Y * 2) modulo 2^32, with X and Y unsigned. It is refreshed in the same edge that writes X or Y. Code 12 writes X from `operand` and code 13 writes Y from `operand`; neither changes the accumulator or the flags.
- R3: Code 4 (add) and code 2 (subtract) replace the accumulator's upper 16 bits with the upper half plus or minus `operand`, modulo 2^16. The lower 16 bits are kept.
- R4: Code 3 (compare) computes the subtract result and sets Z and N from it, with the lower half kept. The accumulator is not written.
- R5: Codes 5, 6 and 7 (AND, OR, XOR) combine the accumulator with `operand` placed in bits 31..16 and zeros below, so AND clears bits 15..0.
- R6: Every operation that writes the accumulator sets Z when the new 32-bit value is zero and copies bit 31 into N. `status_out` carries Z in bit 13 and N in bit 15, and all its other bits are zero.
- R7: Code 8 is a single-operand operation selected by `operand[2:0]`: 2 shifts right logically by one, 3 shifts left by one, 6 takes the two's complement, and 7 takes the two's complement only if bit 31 is set. Any other selector leaves the accumulator value unchanged, while Z/N are still recomputed from it.
- R8: Code 9 (multiply-accumulate) adds the P held before the edge to the accumulator, modulo 2^32. It loads X from `mul_x` and Y from `mul_y`, and P becomes the new product.
- R9: Code 10 (multiply-load) clears the accumulator and loads X from `mul_x` and Y from `mul_y`.
- R10: Code 11 copies the current 32-bit P into the accumulator.
- R11: Code 1 (load) writes `operand` into the accumulator's upper half and keeps the lower half.
- R12: `cond_true` is combinational. It is 1 for `cond_code` 0x00, Z==`cond_sel` for 0x50, N==`cond_sel` for 0x70, and 0 for any other code.
- R13: When `op_valid` is low, and for codes 0, 14 and 15, the accumulator, P and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Apply `op_code` at this edge |
| op_code | input | 4 | Operation code (see requirements) |
| operand | input | 16 | Operand value, or unary selector in bits 2..0 |
| mul_x | input | 16 | New X for multiply-accumulate and multiply-load |
| mul_y | input | 16 | New Y for multiply-accumulate and multiply-load |
| cond_code | input | 8 | Branch condition code |
| cond_sel | input | 1 | Flag value the condition is compared with |
| acc_out | output | 32 | Accumulator |
| prod_out | output | 32 | Product register P |
| status_out | output | 16 | Flags: Z in bit 13, N in bit 15 |
| cond_true | output | 1 | Condition evaluates true |

## Verification
The accumulator, P and the flags are all one register stage from the inputs. Their new values are due at the first rising edge after `op_valid` is seen high. The bench drives every operation on a falling edge and compares at the next falling edge, half a cycle after the update. `cond_true` has no register in its path. It is checked a short delay after `cond_code` and `cond_sel` change, with the flags held still by a low `op_valid`.

// File: rtl/dsp_acc_pkg.sv
package dsp_acc_pkg;

    typedef enum logic [3:0] {
        OPC_NOP   = 4'd0,
        OPC_LOAD  = 4'd1,
        OPC_SUB   = 4'd2,
        OPC_CMP   = 4'd3,
        OPC_ADD   = 4'd4,
        OPC_AND   = 4'd5,
        OPC_OR    = 4'd6,
        OPC_XOR   = 4'd7,
        OPC_UNARY = 4'd8,
        OPC_MAC   = 4'd9,
        OPC_MLD   = 4'd10,
        OPC_MOVP  = 4'd11,
        OPC_WRX   = 4'd12,
        OPC_WRY   = 4'd13
    } acc_op_e;

    localparam logic [2:0] UN_LSR = 3'd2;
    localparam logic [2:0] UN_SHL = 3'd3;
    localparam logic [2:0] UN_NEG = 3'd6;
    localparam logic [2:0] UN_ABS = 3'd7;

    localparam logic [7:0] CC_ALWAYS = 8'h00;
    localparam logic [7:0] CC_ZERO   = 8'h50;
    localparam logic [7:0] CC_NEG    = 8'h70;

endpackage

// File: rtl/dsp_acc_mul.sv
module dsp_acc_mul #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   x_val,
    input  logic [DW-1:0]   y_val,
    output logic [2*DW-1:0] prod
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] raw;

    always_comb begin
        raw  = PW'(x_val) * PW'(y_val);
        prod = {raw[PW-2:0], 1'b0};
    end
endmodule

// File: rtl/dsp_acc_alu.sv
module dsp_acc_alu
    import dsp_acc_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [3:0]      op,
    input  logic [DW-1:0]   operand,
    input  logic [2*DW-1:0] acc,
    input  logic [2*DW-1:0] prod,
    output logic [2*DW-1:0] acc_nx,
    output logic            acc_we,
    output logic            flag_we,
    output logic [2*DW-1:0] flag_src
);
    localparam int AW = 2 * DW;

    logic [DW-1:0] hi;
    logic [DW-1:0] lo;
    logic [DW-1:0] diff;
    logic [AW-1:0] wide_opnd;

    always_comb begin
        hi        = acc[AW-1:DW];
        lo        = acc[DW-1:0];
        diff      = hi - operand;
        wide_opnd = {operand, {DW{1'b0}}};
        acc_nx    = acc;
        acc_we    = 1'b0;
        flag_we   = 1'b0;
        flag_src  = acc;
        unique case (op)
            OPC_LOAD: begin acc_nx = {operand, lo};        acc_we = 1'b1; end
            OPC_SUB:  begin acc_nx = {diff, lo};           acc_we = 1'b1; end
            OPC_ADD:  begin acc_nx = {hi + operand, lo};   acc_we = 1'b1; end
            OPC_AND:  begin acc_nx = acc & wide_opnd;      acc_we = 1'b1; end
            OPC_OR:   begin acc_nx = acc | wide_opnd;      acc_we = 1'b1; end
            OPC_XOR:  begin acc_nx = acc ^ wide_opnd;      acc_we = 1'b1; end
            OPC_MAC:  begin acc_nx = acc + prod;           acc_we = 1'b1; end
            OPC_MLD:  begin acc_nx = '0;                   acc_we = 1'b1; end
            OPC_MOVP: begin acc_nx = prod;                 acc_we = 1'b1; end
            OPC_CMP:  begin flag_src = {diff, lo};         flag_we = 1'b1; end
            OPC_UNARY: begin
                acc_we = 1'b1;
                unique case (operand[2:0])
                    UN_LSR:  acc_nx = {1'b0, acc[AW-1:1]};
                    UN_SHL:  acc_nx = {acc[AW-2:0], 1'b0};
                    UN_NEG:  acc_nx = -acc;
                    UN_ABS:  acc_nx = acc[AW-1] ? -acc : acc;
                    default: acc_nx = acc;
                endcase
            end
            default: ;
        endcase
        if (acc_we) begin
            flag_we  = 1'b1;
            flag_src = acc_nx;
        end
    end
endmodule

// File: rtl/dsp_acc_cond.sv
module dsp_acc_cond
    import dsp_acc_pkg::*;
(
    input  logic [7:0] cond_code,
    input  logic       cond_sel,
    input  logic       z,
    input  logic       n,
    output logic       hit
);
    always_comb begin
        unique case (cond_code)
            CC_ALWAYS: hit = 1'b1;
            CC_ZERO:   hit = (z == cond_sel);
            CC_NEG:    hit = (n == cond_sel);
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/dsp_acc_unit.sv
module dsp_acc_unit
    import dsp_acc_pkg::*;
#(
    parameter int DW     = 16,
    parameter int SW     = 16,
    parameter int Z_BIT  = 13,
    parameter int N_BIT  = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [3:0]      op_code,
    input  logic [DW-1:0]   operand,
    input  logic [DW-1:0]   mul_x,
    input  logic [DW-1:0]   mul_y,
    input  logic [7:0]      cond_code,
    input  logic            cond_sel,
    output logic [2*DW-1:0] acc_out,
    output logic [2*DW-1:0] prod_out,
    output logic [SW-1:0]   status_out,
    output logic            cond_true
);
    localparam int AW = 2 * DW;

    logic [AW-1:0] acc_q, prod_q;
    logic [DW-1:0] x_q, y_q;
    logic          z_q, n_q;

    logic [AW-1:0] acc_nx, flag_src, prod_nx;
    logic          acc_we, flag_we;
    logic [DW-1:0] x_nx, y_nx;

    always_comb begin
        x_nx = x_q;
        y_nx = y_q;
        unique case (op_code)
            OPC_WRX: x_nx = operand;
            OPC_WRY: y_nx = operand;
            OPC_MAC, OPC_MLD: begin
                x_nx = mul_x;
                y_nx = mul_y;
            end
            default: ;
        endcase
    end

    dsp_acc_alu #(.DW(DW)) alu_i (
        .op       (op_code),
        .operand  (operand),
        .acc      (acc_q),
        .prod     (prod_q),
        .acc_nx   (acc_nx),
        .acc_we   (acc_we),
        .flag_we  (flag_we),
        .flag_src (flag_src)
    );

    dsp_acc_mul #(.DW(DW)) mul_i (
        .x_val (x_nx),
        .y_val (y_nx),
        .prod  (prod_nx)
    );

    dsp_acc_cond cond_i (
        .cond_code (cond_code),
        .cond_sel  (cond_sel),
        .z         (z_q),
        .n         (n_q),
        .hit       (cond_true)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            prod_q <= '0;
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= 1'b0;
            n_q    <= 1'b0;
        end else if (op_valid) begin
            x_q    <= x_nx;
            y_q    <= y_nx;
            prod_q <= prod_nx;
            if (acc_we) acc_q <= acc_nx;
            if (flag_we) begin
                z_q <= (flag_src == '0);
                n_q <= flag_src[AW-1];
            end
        end
    end

    for (genvar b = 0; b < SW; b++) begin : g_status
        if (b == Z_BIT) begin : g_z
            assign status_out[b] = z_q;
        end else if (b == N_BIT) begin : g_n
            assign status_out[b] = n_q;
        end else begin : g_zero
            assign status_out[b] = 1'b0;
        end
    end

    assign acc_out  = acc_q;
    assign prod_out = prod_q;
endmodule

// File: rtl/dsp_acc_chk.sv
module dsp_acc_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [3:0]  op_code,
    input logic [7:0]  cond_code,
    input logic [31:0] acc_out,
    input logic [31:0] prod_out,
    input logic [15:0] status_out,
    input logic        cond_true
);
    logic writes_acc;
    assign writes_acc = op_valid && (op_code != 4'd0) && (op_code != 4'd3) && (op_code < 4'd12);

    p_idle_hold_r13: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(acc_out) && $stable(prod_out) && $stable(status_out));

    p_cmp_keeps_acc_r4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd3) |=> $stable(acc_out));

    p_and_clears_low_r5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd5) |=> acc_out[15:0] == 16'h0000);

    p_mld_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 4'd10) |=> acc_out == 32'h0 && status_out[13]);

    p_flags_track_r6: assert property (@(posedge clk) disable iff (rst)
        writes_acc |=> status_out[13] == (acc_out == 32'h0) && status_out[15] == acc_out[31]);

    p_cond_always_r12: assert property (@(posedge clk) disable iff (rst)
        cond_code == 8'h00 |-> cond_true);
endmodule

bind dsp_acc_unit dsp_acc_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .cond_code  (cond_code),
    .acc_out    (acc_out),
    .prod_out   (prod_out),
    .status_out (status_out),
    .cond_true  (cond_true)
);

// File: tb/dsp_acc_unit_tb_top.sv
`timescale 1ns/1ps
module dsp_acc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [15:0] operand, mul_x, mul_y;
    logic [7:0]  cond_code;
    logic        cond_sel;
    logic [31:0] acc_out, prod_out;
    logic [15:0] status_out;
    logic        cond_true;

    int errors = 0;
    int checks = 0;

    logic [31:0] m_acc, m_p;
    logic [15:0] m_x, m_y;
    logic        m_z, m_n;
    logic [31:0] seed = 32'h1234_5678;

    always #2 clk = ~clk;

    dsp_acc_unit dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .operand(operand), .mul_x(mul_x), .mul_y(mul_y),
        .cond_code(cond_code), .cond_sel(cond_sel),
        .acc_out(acc_out), .prod_out(prod_out), .status_out(status_out),
        .cond_true(cond_true)
    );

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd1: return "R11";  4'd2: return "R3";  4'd3: return "R4";
            4'd4: return "R3";   4'd5: return "R5";  4'd6: return "R5";
            4'd7: return "R5";   4'd8: return "R7";  4'd9: return "R8";
            4'd10: return "R9";  4'd11: return "R10"; 4'd12: return "R2";
            4'd13: return "R2";  default: return "R13";
        endcase
    endfunction

    function automatic logic [31:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic model_step(input logic [3:0] c, input logic [15:0] v,
                              input logic [15:0] mx, input logic [15:0] my);
        logic [31:0] res;
        logic        wr, fl;
        logic [15:0] hi;
        hi  = m_acc[31:16];
        res = m_acc;
        wr  = 1'b1;
        fl  = 1'b1;
        case (c)
            4'd1:  res = {v, m_acc[15:0]};
            4'd2:  res = {16'(hi - v), m_acc[15:0]};
            4'd3:  begin res = {16'(hi - v), m_acc[15:0]}; wr = 1'b0; end
            4'd4:  res = {16'(hi + v), m_acc[15:0]};
            4'd5:  res = m_acc & {v, 16'h0};
            4'd6:  res = m_acc | {v, 16'h0};
            4'd7:  res = m_acc ^ {v, 16'h0};
            4'd8: begin
                if (v[2:0] == 3'd2) res = m_acc >> 1;
                else if (v[2:0] == 3'd3) res = m_acc << 1;
                else if (v[2:0] == 3'd6) res = 32'(0 - m_acc);
                else if (v[2:0] == 3'd7 && m_acc[31]) res = 32'(0 - m_acc);
            end
            4'd9:  res = m_acc + m_p;
            4'd10: res = 32'h0;
            4'd11: res = m_p;
            default: begin wr = 1'b0; fl = 1'b0; end
        endcase
        if (fl) begin
            m_z = (res == 32'h0);
            m_n = res[31];
        end
        if (wr) m_acc = res;
        if (c == 4'd12) m_x = v;
        if (c == 4'd13) m_y = v;
        if (c == 4'd9 || c == 4'd10) begin m_x = mx; m_y = my; end
        m_p = (32'(m_x) * 32'(m_y)) << 1;
    endtask

    task automatic compare(input string tag);
        logic [15:0] exp_st;
        exp_st = {m_n, 1'b0, m_z, 13'h0};
        checks++;
        if (acc_out !== m_acc || prod_out !== m_p || status_out !== exp_st) begin
            errors++;
            $display("FAIL %s: acc=%h prod=%h st=%h expected acc=%h prod=%h st=%h",
                     tag, acc_out, prod_out, status_out, m_acc, m_p, exp_st);
        end
    endtask

    task automatic run_op(input logic [3:0] c, input logic [15:0] v,
                          input logic [15:0] mx, input logic [15:0] my);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; operand = v; mul_x = mx; mul_y = my;
        @(negedge clk);
        op_valid = 1'b0;
        model_step(c, v, mx, my);
        compare(req_of(c));
    endtask

    task automatic idle_op(input logic [3:0] c, input logic [15:0] v);
        @(negedge clk);
        op_valid = 1'b0; op_code = c; operand = v; mul_x = v; mul_y = ~v;
        @(negedge clk);
        compare("R13 idle");
    endtask

    task automatic check_cond(input logic [7:0] cc, input logic s);
        logic exp;
        cond_code = cc; cond_sel = s;
        #1;
        if (cc == 8'h00) exp = 1'b1;
        else if (cc == 8'h50) exp = (m_z == s);
        else if (cc == 8'h70) exp = (m_n == s);
        else exp = 1'b0;
        checks++;
        if (cond_true !== exp) begin
            errors++;
            $display("FAIL R12: cc=%h sel=%0b cond_true=%0b expected %0b", cc, s, cond_true, exp);
        end
        cond_code = 8'h00;
    endtask

    task automatic cond_sweep();
        logic [7:0] codes [5];
        codes = '{8'h00, 8'h50, 8'h70, 8'h10, 8'hFF};
        for (int i = 0; i < 5; i++) begin
            check_cond(codes[i], 1'b0);
            check_cond(codes[i], 1'b1);
        end
    endtask

    initial begin
        #400_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_code = 4'd0; operand = '0;
        mul_x = '0; mul_y = '0; cond_code = 8'h00; cond_sel = 1'b0;
        m_acc = '0; m_p = '0; m_x = '0; m_y = '0; m_z = 1'b0; m_n = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare("R1 reset");

        // directed corner cases
        run_op(4'd1, 16'h8000, 0, 0);      // R11 load -> N set
        run_op(4'd8, 16'd3, 0, 0);         // R7 shift left out -> zero
        run_op(4'd1, 16'h1234, 0, 0);
        run_op(4'd6, 16'h00FF, 0, 0);
        run_op(4'd10, 0, 16'hFFFF, 16'hFFFF); // R9 and R2 wrap of P
        run_op(4'd11, 0, 0, 0);            // R10 copy P
        run_op(4'd3, 16'hFFFE, 0, 0);      // R4 compare keeps acc
        run_op(4'd5, 16'hF0F0, 0, 0);      // R5 AND clears low half
        run_op(4'd1, 16'h8000, 0, 0);
        run_op(4'd5, 16'h8000, 0, 0);
        run_op(4'd8, 16'd7, 0, 0);         // R7 abs of most negative
        run_op(4'd8, 16'd0, 0, 0);         // R7 unknown selector
        run_op(4'd9, 0, 16'd3, 16'd5);     // R8 add old P, new operands
        run_op(4'd9, 0, 16'd1, 16'd1);
        run_op(4'd0, 16'hFFFF, 0, 0);      // R13 nop code
        run_op(4'd14, 16'hFFFF, 0, 0);
        run_op(4'd15, 16'hFFFF, 0, 0);
        idle_op(4'd10, 16'hABCD);          // R13 strobe low
        idle_op(4'd12, 16'h5555);
        cond_sweep();

        // sweep: every code, many operand patterns
        for (int it = 0; it < 60; it++) begin
            for (int c = 0; c < 16; c++) begin
                logic [31:0] r;
                r = next_rand();
                run_op(4'(c), r[15:0], r[31:16], r[23:8]);
                if ((c % 5) == 0) cond_sweep();
            end
            idle_op(4'(it), seed[15:0]);
        end

        // unary selector sweep over all eight codes from a negative value
        for (int s = 0; s < 8; s++) begin
            run_op(4'd1, 16'hC001, 0, 0);
            run_op(4'd8, 16'(s), 0, 0);
            cond_sweep();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule